// File: doc/BRIEF.md
# Interlocked Strobe Bus Link

This block moves single read and write transfers between a local requester and a memory array over a bus that carries no shared clock. A master controller sits on the requester side. It presents the address, a memory-request qualifier and a read qualifier on the bus. Once these lines have settled, it raises its strobe. A slave controller sits on the array side. It waits for that strobe, performs the access on the array, and answers with its own strobe. Each strobe is released only in response to the other. The transfer therefore lasts exactly as long as the slave needs, and the master needs no knowledge of the slave's speed.

Each side receives the other side's strobe through a chain of synchronizing flops, so the two controllers may later be placed in separate clock domains. The master counts the cycles it spends waiting for the slave's answer. If the answer does not arrive in time, the master abandons the transfer, reports a bus error and returns to idle. The slave drives the shared data lines only while it is returning read data. At all other times it presents them as released.

Top module: `strobe_bus_link`

## Requirements
- R1: When the master raises its strobe (`bus_msyn`), the address, memory-request and read lines have already been driven for at least one cycle, and `bus_mreq` is high.
- R2: The slave starts an array access (`mem_req` rising) only after it has seen the master strobe high through its synchronizer.
- R3: The master lowers its strobe only after it has seen the slave strobe (`bus_ssyn`) high, or when it aborts on timeout.
- R4: The slave lowers its strobe only after it has seen the master strobe low, and it then completes the cycle.
- R5: Transfer latency follows the array: each extra cycle the array takes before `mem_ack` adds exactly one cycle between request acceptance and `rsp_valid`.
- R6: A read returns on `rsp_rdata` the word the array supplied. A write delivers `req_wdata` to `mem_wdata` at `req_addr`, with `mem_we` high.
- R7: Address, memory-request and read lines stay stable from before the master strobe rises until the master has seen the slave strobe low again.
- R8: If the slave strobe is not seen within TIMEOUT_CYC cycles of the master strobe rising, the master strobe falls after exactly TIMEOUT_CYC cycles high. The master then pulses `rsp_valid` with `rsp_err` set and returns to idle.
- R9: The slave's data drivers (`slave_drv_en`) are on only while the slave strobe is high for a read, and are off otherwise.
- R10: After reset both strobes and `mem_req` are low, `rsp_valid` is low and `req_ready` is high.
- R11: The master refuses a new request (`req_ready` low) while it still sees the slave strobe high, for example one that arrives late after an abort.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both controllers |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Local transfer request |
| req_ready | output | 1 | Master can accept a request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Transfer address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Completion was a timeout abort |
| rsp_rdata | output | DATA_W | Read data captured from the bus |
| mem_req | output | 1 | Array access request, held until acknowledged |
| mem_we | output | 1 | Array access is a write |
| mem_addr | output | ADDR_W | Array address |
| mem_wdata | output | DATA_W | Array write data |
| mem_ack | input | 1 | Array finished the access |
| mem_rdata | input | DATA_W | Array read data, valid with mem_ack |
| bus_addr | output | ADDR_W | Observed bus address lines |
| bus_mreq | output | 1 | Observed memory-request qualifier |
| bus_rd | output | 1 | Observed read qualifier |
| bus_msyn | output | 1 | Observed master strobe |
| bus_ssyn | output | 1 | Observed slave strobe |
| bus_data | output | DATA_W | Observed resolved data lines (zero when nobody drives) |
| slave_drv_en | output | 1 | Slave data drivers enabled |

## Verification
A master stuck in the wrong state appears at the bus strobes within one cycle. Examples are a strobe that rises before the qualifiers, that falls without an answer, or that stays high past the timeout. A wrong slave state appears either as an array request with no master strobe behind it, or as a slave strobe that never drops. A corrupted capture register appears on `rsp_rdata` at the completion pulse of the same transfer. A wrong timeout count shifts the abort by a measurable number of cycles. Because the strobes interlock, a single missing transition stalls the link, and the bound on response latency exposes it.

// File: rtl/strobe_bus_pkg.sv
package strobe_bus_pkg;
   typedef enum logic [1:0] {
      M_IDLE    = 2'd0,
      M_SETUP   = 2'd1,
      M_STROBE  = 2'd2,
      M_RELEASE = 2'd3
   } mst_state_e;

   typedef enum logic [1:0] {
      S_IDLE   = 2'd0,
      S_ACCESS = 2'd1,
      S_HOLD   = 2'd2
   } slv_state_e;
endpackage

// File: rtl/strobe_sync.sv
module strobe_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   logic [STAGES-1:0] chain_q;

   initial assert (STAGES >= 2) else $error("strobe_sync: STAGES must be at least 2");

   genvar g;
   generate
      for (g = 0; g < STAGES; g++) begin : g_stage
         if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[0] <= 1'b0;
               else        chain_q[0] <= d_i;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[g] <= 1'b0;
               else        chain_q[g] <= chain_q[g-1];
            end
         end
      end
   endgenerate

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/strobe_master.sv
module strobe_master
   import strobe_bus_pkg::*;
#(
   parameter int ADDR_W      = 16,
   parameter int DATA_W      = 16,
   parameter int SYNC_STAGES = 2,
   parameter int TIMEOUT_CYC = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid_i,
   output logic              req_ready_o,
   input  logic              req_we_i,
   input  logic [ADDR_W-1:0] req_addr_i,
   input  logic [DATA_W-1:0] req_wdata_i,
   output logic              rsp_valid_o,
   output logic              rsp_err_o,
   output logic [DATA_W-1:0] rsp_rdata_o,
   output logic [ADDR_W-1:0] bus_addr_o,
   output logic              bus_mreq_o,
   output logic              bus_rd_o,
   output logic              bus_msyn_o,
   input  logic              bus_ssyn_i,
   input  logic [DATA_W-1:0] bus_data_i,
   output logic [DATA_W-1:0] bus_data_o,
   output logic              bus_data_oe_o
);
   localparam int CNT_W = $clog2(TIMEOUT_CYC + 1);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT_CYC - 1);

   initial assert (TIMEOUT_CYC >= 2) else $error("strobe_master: TIMEOUT_CYC too small");

   mst_state_e        st_q;
   logic [CNT_W-1:0]  wait_q;
   logic              ssyn_s;

   strobe_sync #(.STAGES(SYNC_STAGES)) u_ssyn_sync (
      .clk(clk), .rst_n(rst_n), .d_i(bus_ssyn_i), .q_o(ssyn_s)
   );

   assign req_ready_o = (st_q == M_IDLE) && !ssyn_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q          <= M_IDLE;
         wait_q        <= '0;
         bus_addr_o    <= '0;
         bus_mreq_o    <= 1'b0;
         bus_rd_o      <= 1'b0;
         bus_msyn_o    <= 1'b0;
         bus_data_o    <= '0;
         bus_data_oe_o <= 1'b0;
         rsp_valid_o   <= 1'b0;
         rsp_err_o     <= 1'b0;
         rsp_rdata_o   <= '0;
      end else begin
         rsp_valid_o <= 1'b0;
         unique case (st_q)
            M_IDLE: begin
               if (req_valid_i && req_ready_o) begin
                  bus_addr_o    <= req_addr_i;
                  bus_mreq_o    <= 1'b1;
                  bus_rd_o      <= !req_we_i;
                  bus_data_o    <= req_wdata_i;
                  bus_data_oe_o <= req_we_i;
                  rsp_err_o     <= 1'b0;
                  st_q          <= M_SETUP;
               end
            end
            M_SETUP: begin
               bus_msyn_o <= 1'b1;
               wait_q     <= '0;
               st_q       <= M_STROBE;
            end
            M_STROBE: begin
               if (ssyn_s) begin
                  bus_msyn_o <= 1'b0;
                  if (bus_rd_o) rsp_rdata_o <= bus_data_i;
                  st_q <= M_RELEASE;
               end else if (wait_q == CNT_LAST) begin
                  bus_msyn_o    <= 1'b0;
                  bus_mreq_o    <= 1'b0;
                  bus_rd_o      <= 1'b0;
                  bus_data_oe_o <= 1'b0;
                  rsp_valid_o   <= 1'b1;
                  rsp_err_o     <= 1'b1;
                  st_q          <= M_IDLE;
               end else begin
                  wait_q <= wait_q + 1'b1;
               end
            end
            M_RELEASE: begin
               if (!ssyn_s) begin
                  bus_mreq_o    <= 1'b0;
                  bus_rd_o      <= 1'b0;
                  bus_data_oe_o <= 1'b0;
                  rsp_valid_o   <= 1'b1;
                  st_q          <= M_IDLE;
               end
            end
            default: st_q <= M_IDLE;
         endcase
      end
   end

   a_r1_qualifiers_first: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_msyn_o) |-> bus_mreq_o && $stable(bus_addr_o) && $stable(bus_rd_o));

   a_r3_msyn_falls_on_answer: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(bus_msyn_o) |-> ($past(ssyn_s) || rsp_err_o));

   a_r7_lines_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == M_STROBE || st_q == M_RELEASE) |->
         bus_mreq_o && $stable(bus_addr_o) && $stable(bus_rd_o));

   a_r11_no_accept_while_ssyn: assert property (@(posedge clk) disable iff (!rst_n)
      ssyn_s |-> !req_ready_o);
endmodule

// File: rtl/strobe_slave.sv
module strobe_slave
   import strobe_bus_pkg::*;
#(
   parameter int ADDR_W      = 16,
   parameter int DATA_W      = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr_i,
   input  logic              bus_mreq_i,
   input  logic              bus_rd_i,
   input  logic              bus_msyn_i,
   output logic              bus_ssyn_o,
   input  logic [DATA_W-1:0] bus_data_i,
   output logic [DATA_W-1:0] bus_data_o,
   output logic              bus_data_oe_o,
   output logic              mem_req_o,
   output logic              mem_we_o,
   output logic [ADDR_W-1:0] mem_addr_o,
   output logic [DATA_W-1:0] mem_wdata_o,
   input  logic              mem_ack_i,
   input  logic [DATA_W-1:0] mem_rdata_i
);
   slv_state_e st_q;
   logic       msyn_s;
   logic       is_rd_q;

   strobe_sync #(.STAGES(SYNC_STAGES)) u_msyn_sync (
      .clk(clk), .rst_n(rst_n), .d_i(bus_msyn_i), .q_o(msyn_s)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q          <= S_IDLE;
         is_rd_q       <= 1'b0;
         bus_ssyn_o    <= 1'b0;
         bus_data_o    <= '0;
         bus_data_oe_o <= 1'b0;
         mem_req_o     <= 1'b0;
         mem_we_o      <= 1'b0;
         mem_addr_o    <= '0;
         mem_wdata_o   <= '0;
      end else begin
         unique case (st_q)
            S_IDLE: begin
               if (msyn_s && bus_mreq_i) begin
                  mem_req_o   <= 1'b1;
                  mem_we_o    <= !bus_rd_i;
                  mem_addr_o  <= bus_addr_i;
                  mem_wdata_o <= bus_data_i;
                  is_rd_q     <= bus_rd_i;
                  st_q        <= S_ACCESS;
               end
            end
            S_ACCESS: begin
               if (mem_ack_i) begin
                  mem_req_o     <= 1'b0;
                  bus_data_o    <= mem_rdata_i;
                  bus_data_oe_o <= is_rd_q;
                  bus_ssyn_o    <= 1'b1;
                  st_q          <= S_HOLD;
               end
            end
            S_HOLD: begin
               if (!msyn_s) begin
                  bus_ssyn_o    <= 1'b0;
                  bus_data_oe_o <= 1'b0;
                  st_q          <= S_IDLE;
               end
            end
            default: st_q <= S_IDLE;
         endcase
      end
   end

   a_r2_access_after_msyn: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_req_o) |-> $past(msyn_s));

   a_r4_ssyn_falls_after_msyn: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(bus_ssyn_o) |-> !$past(msyn_s));

   a_r9_drive_only_in_read_answer: assert property (@(posedge clk) disable iff (!rst_n)
      bus_data_oe_o |-> (bus_ssyn_o && is_rd_q));
endmodule

// File: rtl/strobe_bus_link.sv
module strobe_bus_link #(
   parameter int ADDR_W      = 16,
   parameter int DATA_W      = 16,
   parameter int SYNC_STAGES = 2,
   parameter int TIMEOUT_CYC = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_we,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rsp_valid,
   output logic              rsp_err,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic              mem_ack,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic [ADDR_W-1:0] bus_addr,
   output logic              bus_mreq,
   output logic              bus_rd,
   output logic              bus_msyn,
   output logic              bus_ssyn,
   output logic [DATA_W-1:0] bus_data,
   output logic              slave_drv_en
);
   initial assert (ADDR_W >= 1 && DATA_W >= 1) else $error("strobe_bus_link: bad widths");

   logic [DATA_W-1:0] m_data, s_data;
   logic              m_oe;

   strobe_master #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W),
      .SYNC_STAGES(SYNC_STAGES), .TIMEOUT_CYC(TIMEOUT_CYC)
   ) u_master (
      .clk(clk), .rst_n(rst_n),
      .req_valid_i(req_valid), .req_ready_o(req_ready), .req_we_i(req_we),
      .req_addr_i(req_addr), .req_wdata_i(req_wdata),
      .rsp_valid_o(rsp_valid), .rsp_err_o(rsp_err), .rsp_rdata_o(rsp_rdata),
      .bus_addr_o(bus_addr), .bus_mreq_o(bus_mreq), .bus_rd_o(bus_rd),
      .bus_msyn_o(bus_msyn), .bus_ssyn_i(bus_ssyn),
      .bus_data_i(bus_data), .bus_data_o(m_data), .bus_data_oe_o(m_oe)
   );

   strobe_slave #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)
   ) u_slave (
      .clk(clk), .rst_n(rst_n),
      .bus_addr_i(bus_addr), .bus_mreq_i(bus_mreq), .bus_rd_i(bus_rd),
      .bus_msyn_i(bus_msyn), .bus_ssyn_o(bus_ssyn),
      .bus_data_i(bus_data), .bus_data_o(s_data), .bus_data_oe_o(slave_drv_en),
      .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
      .mem_wdata_o(mem_wdata), .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata)
   );

   assign bus_data = slave_drv_en ? s_data : (m_oe ? m_data : '0);

   a_r9_single_driver: assert property (@(posedge clk) disable iff (!rst_n)
      !(slave_drv_en && m_oe));
endmodule

// File: tb/strobe_bus_link_tb_top.sv
module strobe_bus_link_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 16;
   localparam int DW = 16;
   localparam int TMO = 64;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0, req_we = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic          req_ready, rsp_valid, rsp_err;
   logic [DW-1:0] rsp_rdata;
   logic          mem_req, mem_we;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_wdata;
   logic          mem_ack = 1'b0;
   logic [DW-1:0] mem_rdata = '0;
   logic [AW-1:0] bus_addr;
   logic          bus_mreq, bus_rd, bus_msyn, bus_ssyn, slave_drv_en;
   logic [DW-1:0] bus_data;

   int tests = 0, fails = 0;
   int mem_delay = 0;
   bit mem_stall = 0;
   int acc_cnt = 0;
   logic [DW-1:0] model_mem [0:255];
   bit cur_rd = 0;
   int last_wr_addr = -1;
   logic [DW-1:0] last_wr_data = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   strobe_bus_link #(.ADDR_W(AW), .DATA_W(DW), .SYNC_STAGES(2), .TIMEOUT_CYC(TMO)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
      .req_addr(req_addr), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_ack(mem_ack), .mem_rdata(mem_rdata),
      .bus_addr(bus_addr), .bus_mreq(bus_mreq), .bus_rd(bus_rd),
      .bus_msyn(bus_msyn), .bus_ssyn(bus_ssyn), .bus_data(bus_data),
      .slave_drv_en(slave_drv_en)
   );

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // array model: acknowledges after mem_delay cycles of a held request
   always @(negedge clk) begin
      if (!mem_req) begin
         mem_ack <= 1'b0;
         acc_cnt <= 0;
      end else if (!mem_ack && !mem_stall) begin
         if (acc_cnt >= mem_delay) begin
            mem_ack   <= 1'b1;
            mem_rdata <= model_mem[mem_addr[7:0]];
            if (mem_we) begin
               model_mem[mem_addr[7:0]] <= mem_wdata;
               last_wr_addr = int'(mem_addr);
               last_wr_data = mem_wdata;
            end
         end else begin
            acc_cnt <= acc_cnt + 1;
         end
      end
   end

   // per-clock protocol model, sampled away from the active edge
   logic          p_msyn = 0, p_ssyn = 0, p_mreq = 0, p_rd = 0, p_memreq = 0;
   logic [AW-1:0] p_addr = '0;
   bit            ssyn_seen_since_msyn = 0;
   bit            msyn_low_seen = 1;
   always @(negedge clk) begin
      if (rst_n) begin
         if (bus_msyn && !p_msyn)  // R1
            check(bus_mreq && p_mreq && bus_addr == p_addr && bus_rd == p_rd,
                  "R1 qualifiers before strobe", bus_addr, p_addr);
         if (p_msyn && !bus_msyn)  // R3
            check(ssyn_seen_since_msyn || rsp_err, "R3 master strobe release", bus_ssyn, 1);
         if (p_ssyn && !bus_ssyn)  // R4
            check(msyn_low_seen, "R4 slave strobe release", bus_msyn, 0);
         if (mem_req && !p_memreq) // R2
            check(bus_msyn, "R2 access after strobe", bus_msyn, 1);
         if (p_msyn && bus_mreq && p_mreq) // R7
            check(bus_addr == p_addr && bus_rd == p_rd, "R7 lines stable", bus_addr, p_addr);
         if (slave_drv_en || bus_ssyn)      // R9
            check(slave_drv_en == (bus_ssyn && cur_rd), "R9 slave drivers",
                  slave_drv_en, bus_ssyn && cur_rd);
      end
      if (bus_msyn && !p_msyn) ssyn_seen_since_msyn = 0;
      if (bus_ssyn && bus_msyn) ssyn_seen_since_msyn = 1;
      if (bus_ssyn && !p_ssyn) msyn_low_seen = !bus_msyn;
      if (!bus_msyn) msyn_low_seen = 1;
      p_msyn = bus_msyn; p_ssyn = bus_ssyn; p_mreq = bus_mreq; p_rd = bus_rd;
      p_addr = bus_addr; p_memreq = mem_req;
   end

   task automatic xfer(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                       output logic [DW-1:0] rd, output bit err, output int lat);
      req_we = we; req_addr = a; req_wdata = wd; req_valid = 1'b1;
      cur_rd = !we;
      for (int i = 0; i < 1000; i++) begin
         @(negedge clk);
         if (req_ready) break;
      end
      @(negedge clk);
      req_valid = 1'b0;
      lat = 1;
      while (!rsp_valid && lat < 2000) begin
         @(negedge clk);
         lat++;
      end
      rd = rsp_rdata; err = rsp_err;
      check(rsp_valid, "R5 response arrives", lat, 0);
   endtask

   initial begin
      int wd_cnt = 0;
      forever begin
         @(posedge clk);
         wd_cnt++;
         if (wd_cnt > 150000) begin
            fails++; tests++;
            $display("FAIL watchdog actual=%0d expected=<150000", wd_cnt);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
         end
      end
   end

   initial begin
      logic [DW-1:0] rd;
      bit err;
      int lat0, lat3, lat_w, hi_cnt;
      for (int i = 0; i < 256; i++) model_mem[i] = DW'(16'h1000 + i * 7);

      repeat (3) @(negedge clk);
      // R10 reset state
      check(!bus_msyn && !bus_ssyn && !mem_req && !rsp_valid, "R10 reset outputs",
            {bus_msyn, bus_ssyn, mem_req, rsp_valid}, 0);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      check(req_ready, "R10 ready after reset", req_ready, 1);

      // R6 read, fast array
      mem_delay = 0;
      xfer(0, 16'h0005, '0, rd, err, lat0);
      check(rd == DW'(16'h1000 + 5 * 7) && !err, "R6 read data", rd, 16'h1000 + 35);

      // R6 write then read back
      xfer(1, 16'h0042, 16'hBEEF, rd, err, lat_w);
      check(last_wr_addr == 16'h42 && last_wr_data == 16'hBEEF && !err, "R6 write to array",
            last_wr_data, 16'hBEEF);
      xfer(0, 16'h0042, '0, rd, err, lat_w);
      check(rd == 16'hBEEF, "R6 read back written word", rd, 16'hBEEF);

      // R5 slower array adds exactly its extra cycles
      mem_delay = 3;
      xfer(0, 16'h0009, '0, rd, err, lat3);
      check(lat3 - lat0 == 3, "R5 latency tracks array", lat3 - lat0, 3);
      check(rd == DW'(16'h1000 + 9 * 7), "R6 read data slow array", rd, 16'h1000 + 63);
      mem_delay = 7;
      xfer(1, 16'h0011, 16'h1234, rd, err, lat_w);
      check(lat_w - lat0 == 7 && !err, "R5 write latency tracks array", lat_w - lat0, 7);

      // R8 timeout: array never answers
      mem_delay = 0;
      mem_stall = 1;
      req_we = 0; req_addr = 16'h0077; req_valid = 1'b1; cur_rd = 1;
      while (!bus_msyn) @(negedge clk);
      req_valid = 1'b0;
      hi_cnt = 0;
      while (bus_msyn && hi_cnt < 4 * TMO) begin
         hi_cnt++;
         @(negedge clk);
      end
      check(hi_cnt == TMO, "R8 strobe high cycles before abort", hi_cnt, TMO);
      check(rsp_valid && rsp_err, "R8 error response", {rsp_valid, rsp_err}, 3);
      @(negedge clk);
      check(!rsp_valid && !bus_mreq, "R8 back to idle", {rsp_valid, bus_mreq}, 0);

      // R11 late slave answer blocks a new request
      mem_stall = 0;
      while (!bus_ssyn) @(negedge clk);
      @(posedge clk); @(posedge clk); @(negedge clk);
      check(!req_ready, "R11 ready held low while late answer seen", req_ready, 0);
      repeat (6) @(negedge clk);
      check(req_ready && !bus_ssyn, "R11 ready restored", req_ready, 1);

      // recovery after abort
      xfer(0, 16'h0042, '0, rd, err, lat_w);
      check(rd == 16'hBEEF && !err, "R6 read after abort", rd, 16'hBEEF);
      xfer(0, 16'h00FF, '0, rd, err, lat_w);
      check(rd == DW'(16'h1000 + 255 * 7), "R6 read top address", rd, 16'h1000 + 255 * 7);

      repeat (5) @(negedge clk);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule